// File: doc/BRIEF.md
# Serial Pixel Link Word Aligner and Unpacker

This block sits behind the line receivers of a four-lane serial display link. On each fast clock it takes one sampled bit from the clock lane and one from each of four data lanes. Every pixel is carried as a seven-slot word. The block finds where each word starts by looking for the clock-lane slot pattern. Once it has found the boundary, it rebuilds the pixel as parallel 8-bit red, green and blue values plus horizontal sync, vertical sync and data enable.

The pixel can be unpacked in one of three bit orderings. The first is a six-bit-per-colour layout on three lanes. The second is a 24-bit layout in which the fourth lane carries the two least significant bits of each colour. The third is a 24-bit layout in which the fourth lane carries the two most significant bits of each colour. A lock output reports that word alignment has been stable. While lock is low, the block emits no pixels.

Top module: `lvds_deser`

## Requirements
- R1: While `rstN` is low, `locked`, `pixValid`, `framingErr`, the colour outputs and the three control outputs are all 0.
- R2: A word matches when the clock lane reads 1,1,0,0,0,1,1 over its slots 0 to 6. `locked` rises on the fourth consecutive matching word at the same phase. That rise happens one fast clock after the word's last slot is sampled, in the same cycle as the word's `pixValid`.
- R3: While locked, a single mismatching word leaves `locked` high, and any matching word clears the mismatch run. A second consecutive mismatching word drops `locked`.
- R4: While unlocked, each mismatching word moves the assumed word start one fast clock later, so the next word is judged one fast clock after the current one. After a matching word, the next word is judged seven fast clocks later.
- R5: `pixValid` is a one-cycle pulse, one fast clock after the last slot of a word, and it is asserted only when `locked` is high in that same cycle.
- R6: With `mapMode` 0 (or 3), the six colour bits are taken from lanes 0 to 2 and placed in bits 7..2 of each colour output, with bits 1..0 driven to 0. The mapping is: red[7:2] from lane 0 slots 1..6, MSB first; green[2] from lane 0 slot 0; green[7:3] from lane 1 slots 2..6; blue[3:2] from lane 1 slots 0..1; blue[7:4] from lane 2 slots 3..6.
- R7: With `mapMode` 1, lanes 0 to 2 give colour bits 7..2, using the same slot layout as R6. Lane 3 gives bits 1..0: blue from slots 1..2, green from slots 3..4, red from slots 5..6, each pair MSB first.
- R8: With `mapMode` 2, lanes 0 to 2 give colour bits 5..0 in the R6 slot layout. Lane 3 gives bits 7..6: blue from slots 1..2, green from slots 3..4, red from slots 5..6, each pair MSB first.
- R9: In every mode, lane 2 slot 0 drives `dataEnable`, slot 1 drives `vsync` and slot 2 drives `hsync`. All outputs are captured together with `pixValid`.
- R10: In `mapMode` 1 or 2, a 1 on lane 3 slot 0 of a captured word pulses `framingErr` together with that word's `pixValid`. The framing error has no effect on `locked`.
- R11: In `mapMode` 0 or 3, the lane-3 bits have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkLane | input | 1 | Sampled clock-lane bit |
| dataLane | input | 4 | Sampled data-lane bits, lane k on bit k |
| mapMode | input | 2 | Unpack ordering: 0 six-bit, 1 LSBs on lane 3, 2 MSBs on lane 3, 3 as 0 |
| red | output | 8 | Red of the last captured pixel |
| green | output | 8 | Green of the last captured pixel |
| blue | output | 8 | Blue of the last captured pixel |
| hsync | output | 1 | Horizontal sync of the last captured pixel |
| vsync | output | 1 | Vertical sync of the last captured pixel |
| dataEnable | output | 1 | Data enable of the last captured pixel |
| pixValid | output | 1 | One-cycle strobe for a captured pixel |
| locked | output | 1 | Word alignment lock |
| framingErr | output | 1 | Lane-3 slot-0 framing error strobe |

## Verification
The stream begins with a few stray bits, so the aligner has to slide across wrong phases before it locks. This separates the slip-on-mismatch behaviour from a design that only counts words. The bench then sends random pixels in all four mode codes. Random lane-3 content in the six-bit modes shows that lane 3 is ignored there. In the 24-bit modes the two fourth-lane orderings differ in every colour, so a swapped pair or a swapped mode is exposed. A single corrupted clock-lane word is compared against a double one to tell the keep-lock rule from the drop-lock rule. A mid-stream phase jump forces a full unlock, slip and relock. Random slot-0 bits on lane 3 test that framing errors are flagged without disturbing lock.

// File: rtl/lvds_deser_pkg.sv
package lvds_deser_pkg;

  localparam int SLOTS = 7;
  localparam int LANES = 4;
  localparam int HIST_W = SLOTS - 1;
  localparam int COLOR_W = 8;

  // clock lane reads slot 0 in the MSB
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

  typedef enum logic [1:0] {
    MAP_SIX   = 2'd0,
    MAP_LOW24 = 2'd1,
    MAP_HIGH24 = 2'd2,
    MAP_SPARE = 2'd3
  } mapMode_e;

  typedef struct packed {
    logic capture;
  } ctrlStrobe_t;

endpackage

// File: rtl/lvds_deser_ctrl.sv
module lvds_deser_ctrl
  import lvds_deser_pkg::*;
#(
  parameter int LOCK_WORDS = 4,
  parameter int UNLOCK_WORDS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clkLane,
  output ctrlStrobe_t strobe,
  output logic        locked
);

  localparam int MATCH_W = $clog2(LOCK_WORDS + 1);
  localparam int MISS_W = $clog2(UNLOCK_WORDS + 1);
  localparam int CNT_W = $clog2(SLOTS);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);

  logic [CNT_W-1:0]   slotCnt;
  logic [HIST_W-1:0]  clkHist;
  logic [MATCH_W-1:0] matchCnt, matchNext;
  logic [MISS_W-1:0]  missCnt, missNext;
  logic               lockNext;
  logic               wordEnd;
  logic               match;
  logic               slip;

  assign wordEnd = (slotCnt == LAST_SLOT);
  assign match = ({clkHist, clkLane} == CLK_PATTERN);
  assign slip = wordEnd && !match && !locked;

  always_comb begin
    lockNext = locked;
    matchNext = matchCnt;
    missNext = missCnt;
    if (wordEnd) begin
      if (match) begin
        missNext = '0;
        if (!locked) begin
          if (matchCnt == MATCH_W'(LOCK_WORDS - 1)) begin
            lockNext = 1'b1;
            matchNext = '0;
          end else begin
            matchNext = matchCnt + 1'b1;
          end
        end
      end else begin
        matchNext = '0;
        if (locked) begin
          if (missCnt == MISS_W'(UNLOCK_WORDS - 1)) begin
            lockNext = 1'b0;
            missNext = '0;
          end else begin
            missNext = missCnt + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= '0;
      clkHist <= '0;
      matchCnt <= '0;
      missCnt <= '0;
      locked <= 1'b0;
    end else begin
      clkHist <= {clkHist[HIST_W-2:0], clkLane};
      matchCnt <= matchNext;
      missCnt <= missNext;
      locked <= lockNext;
      if (slip) begin
        slotCnt <= slotCnt;
      end else if (wordEnd) begin
        slotCnt <= '0;
      end else begin
        slotCnt <= slotCnt + 1'b1;
      end
    end
  end

  assign strobe.capture = wordEnd && lockNext;

endmodule

// File: rtl/lvds_deser_dp.sv
module lvds_deser_dp
  import lvds_deser_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [LANES-1:0]   dataLane,
  input  logic [1:0]         mapMode,
  input  ctrlStrobe_t        strobe,
  output logic [COLOR_W-1:0] red,
  output logic [COLOR_W-1:0] green,
  output logic [COLOR_W-1:0] blue,
  output logic               hsync,
  output logic               vsync,
  output logic               dataEnable,
  output logic               pixValid,
  output logic               framingErr
);

  localparam int CORE_W = COLOR_W - 2;

  logic [LANES-1:0][HIST_W-1:0] laneHist;
  logic [LANES-1:0][SLOTS-1:0]  word;
  logic [CORE_W-1:0] redCore, greenCore, blueCore;
  logic [COLOR_W-1:0] redNext, greenNext, blueNext;
  logic is24, errNext;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) laneHist[i] <= '0;
      else       laneHist[i] <= {laneHist[i][HIST_W-2:0], dataLane[i]};
    end
    assign word[i] = {laneHist[i], dataLane[i]};
  end

  // slot s of lane k sits at word[k][SLOTS-1-s]
  assign redCore = word[0][5:0];
  assign greenCore = {word[1][4:0], word[0][6]};
  assign blueCore = {word[2][3:0], word[1][6:5]};

  always_comb begin
    unique case (mapMode)
      MAP_LOW24: begin
        redNext = {redCore, word[3][1:0]};
        greenNext = {greenCore, word[3][3:2]};
        blueNext = {blueCore, word[3][5:4]};
      end
      MAP_HIGH24: begin
        redNext = {word[3][1:0], redCore};
        greenNext = {word[3][3:2], greenCore};
        blueNext = {word[3][5:4], blueCore};
      end
      default: begin
        redNext = {redCore, 2'b00};
        greenNext = {greenCore, 2'b00};
        blueNext = {blueCore, 2'b00};
      end
    endcase
  end

  assign is24 = (mapMode == MAP_LOW24) || (mapMode == MAP_HIGH24);
  assign errNext = is24 && word[3][6];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      red <= '0;
      green <= '0;
      blue <= '0;
      hsync <= 1'b0;
      vsync <= 1'b0;
      dataEnable <= 1'b0;
      pixValid <= 1'b0;
      framingErr <= 1'b0;
    end else begin
      pixValid <= strobe.capture;
      framingErr <= strobe.capture && errNext;
      if (strobe.capture) begin
        red <= redNext;
        green <= greenNext;
        blue <= blueNext;
        dataEnable <= word[2][6];
        vsync <= word[2][5];
        hsync <= word[2][4];
      end
    end
  end

endmodule

// File: rtl/lvds_deser.sv
module lvds_deser
  import lvds_deser_pkg::*;
#(
  parameter int LOCK_WORDS = 4,
  parameter int UNLOCK_WORDS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkLane,
  input  logic [3:0] dataLane,
  input  logic [1:0] mapMode,
  output logic [7:0] red,
  output logic [7:0] green,
  output logic [7:0] blue,
  output logic       hsync,
  output logic       vsync,
  output logic       dataEnable,
  output logic       pixValid,
  output logic       locked,
  output logic       framingErr
);

  ctrlStrobe_t strobe;

  lvds_deser_ctrl #(
    .LOCK_WORDS(LOCK_WORDS),
    .UNLOCK_WORDS(UNLOCK_WORDS)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .clkLane(clkLane),
    .strobe(strobe),
    .locked(locked)
  );

  lvds_deser_dp u_dp (
    .clk(clk),
    .rstN(rstN),
    .dataLane(dataLane),
    .mapMode(mapMode),
    .strobe(strobe),
    .red(red),
    .green(green),
    .blue(blue),
    .hsync(hsync),
    .vsync(vsync),
    .dataEnable(dataEnable),
    .pixValid(pixValid),
    .framingErr(framingErr)
  );

endmodule

// File: rtl/lvds_deser_chk.sv
module lvds_deser_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] mapMode,
  input logic [7:0] red,
  input logic [7:0] green,
  input logic [7:0] blue,
  input logic       pixValid,
  input logic       locked,
  input logic       framingErr
);

  p_valid_needs_lock_r5: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> locked);

  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> !pixValid);

  p_lock_rise_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> pixValid);

  p_ferr_with_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    framingErr |-> pixValid);

  p_ferr_mode_r10: assert property (@(posedge clk) disable iff (!rstN)
    framingErr |-> ($past(mapMode) == 2'd1 || $past(mapMode) == 2'd2));

  p_left_justify_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(mapMode) == 2'd0) |->
      (red[1:0] == 2'b00 && green[1:0] == 2'b00 && blue[1:0] == 2'b00));

endmodule

bind lvds_deser lvds_deser_chk u_chk (
  .clk(clk),
  .rstN(rstN),
  .mapMode(mapMode),
  .red(red),
  .green(green),
  .blue(blue),
  .pixValid(pixValid),
  .locked(locked),
  .framingErr(framingErr)
);

// File: tb/lvds_deser_bench.sv
`timescale 1ns/1ps
module lvds_deser_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkLaneDrv = 1'b0;
  logic [3:0] dataLaneDrv = '0;
  logic [1:0] modeDrv = '0;
  logic [7:0] red, green, blue;
  logic hsync, vsync, dataEnable, pixValid, locked, framingErr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lvds_deser u_lvds_deser (
    .clk(clk), .rstN(rstN), .clkLane(clkLaneDrv), .dataLane(dataLaneDrv),
    .mapMode(modeDrv), .red(red), .green(green), .blue(blue),
    .hsync(hsync), .vsync(vsync), .dataEnable(dataEnable),
    .pixValid(pixValid), .locked(locked), .framingErr(framingErr)
  );

  // reference model state
  bit [4:0] win[$];
  int mSlot, mMatch, mMiss;
  bit mLock;
  bit eValid, eFerr, eHs, eVs, eDe;
  bit [7:0] eR, eG, eB;
  bit [1:0] eMode;
  bit pat[7] = '{1, 1, 0, 0, 0, 1, 1};

  function automatic bit lb(int lane, int slot);
    bit [4:0] e;
    e = win[slot];
    return e[lane + 1];
  endfunction

  task automatic modelDecode();
    bit [5:0] r6, g6, b6;
    bit [1:0] r2, g2, b2;
    for (int i = 0; i < 6; i++) r6[i] = lb(0, 6 - i);
    g6[0] = lb(0, 0);
    for (int i = 1; i < 6; i++) g6[i] = lb(1, 7 - i);
    b6[0] = lb(1, 1);
    b6[1] = lb(1, 0);
    for (int i = 2; i < 6; i++) b6[i] = lb(2, 8 - i);
    b2 = {lb(3, 1), lb(3, 2)};
    g2 = {lb(3, 3), lb(3, 4)};
    r2 = {lb(3, 5), lb(3, 6)};
    eMode = modeDrv;
    if (modeDrv == 2'd1) begin
      eR = {r6, r2}; eG = {g6, g2}; eB = {b6, b2};
    end else if (modeDrv == 2'd2) begin
      eR = {r2, r6}; eG = {g2, g6}; eB = {b2, b6};
    end else begin
      eR = {r6, 2'b00}; eG = {g6, 2'b00}; eB = {b6, 2'b00};
    end
    eDe = lb(2, 0);
    eVs = lb(2, 1);
    eHs = lb(2, 2);
    eFerr = (modeDrv == 2'd1 || modeDrv == 2'd2) && lb(3, 0);
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      win.delete();
      repeat (7) win.push_back(5'd0);
      mSlot = 0; mMatch = 0; mMiss = 0; mLock = 0;
      eValid = 0; eFerr = 0; eR = 0; eG = 0; eB = 0; eHs = 0; eVs = 0; eDe = 0;
    end else begin
      bit ok, prevLock;
      win.push_back({dataLaneDrv, clkLaneDrv});
      void'(win.pop_front());
      eValid = 0;
      eFerr = 0;
      if (mSlot == 6) begin
        ok = 1;
        for (int s = 0; s < 7; s++) if (win[s][0] != pat[s]) ok = 0;
        prevLock = mLock;
        if (ok) begin
          mMiss = 0;
          if (!mLock) begin
            mMatch++;
            if (mMatch == 4) begin mLock = 1; mMatch = 0; end
          end
        end else begin
          mMatch = 0;
          if (mLock) begin
            mMiss++;
            if (mMiss == 2) begin mLock = 0; mMiss = 0; end
          end
        end
        mSlot = (!ok && !prevLock) ? 6 : 0;
        if (mLock) begin
          eValid = 1;
          modelDecode();
        end
      end else begin
        mSlot++;
      end
    end
  end

  task automatic chk(bit cond, string tag, int act, int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk(locked == mLock, "R2 R3 R4 locked", locked, mLock);
    chk(pixValid == eValid, "R5 pixValid", pixValid, eValid);
    chk(framingErr == eFerr, "R10 framingErr", framingErr, eFerr);
    if (eValid) begin
      string t;
      t = (eMode == 2'd1) ? "R7 colour" : (eMode == 2'd2) ? "R8 colour" : "R6 R11 colour";
      chk(red == eR, {t, " red"}, red, eR);
      chk(green == eG, {t, " green"}, green, eG);
      chk(blue == eB, {t, " blue"}, blue, eB);
      chk({hsync, vsync, dataEnable} == {eHs, eVs, eDe}, "R9 controls",
          {hsync, vsync, dataEnable}, {eHs, eVs, eDe});
    end
  endtask

  task automatic tick(bit c, bit [3:0] d);
    @(negedge clk);
    compareAll();
    clkLaneDrv = c;
    dataLaneDrv = d;
  endtask

  task automatic sendWord(bit goodClk);
    bit [5:0] r6, g6, b6;
    bit [6:0] l0, l1, l2, l3;
    bit [7:0] r, g, b;
    r = 8'($urandom); g = 8'($urandom); b = 8'($urandom);
    r6 = r[5:0]; g6 = g[5:0]; b6 = b[5:0];
    l0[0] = g6[0];
    for (int s = 1; s < 7; s++) l0[s] = r6[6 - s];
    l1[0] = b6[1];
    l1[1] = b6[0];
    for (int s = 2; s < 7; s++) l1[s] = g6[7 - s];
    l2[0] = 1'($urandom); l2[1] = 1'($urandom); l2[2] = 1'($urandom);
    for (int s = 3; s < 7; s++) l2[s] = b6[8 - s];
    l3 = 7'($urandom);
    l3[0] = ($urandom % 4) == 0;
    for (int s = 0; s < 7; s++)
      tick(goodClk ? pat[s] : 1'b1, {l3[s], l2[s], l1[s], l0[s]});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({locked, pixValid, framingErr} == 3'b000, "R1 reset flags",
        {locked, pixValid, framingErr}, 0);
    chk({red, green, blue, hsync, vsync, dataEnable} == '0, "R1 reset data", red, 0);
    rstN = 1'b1;
    modeDrv = 2'd0;
    tick(1, 4'h5); tick(0, 4'ha); tick(1, 4'h3);
    repeat (12) sendWord(1);
    @(negedge clk);
    chk(locked == 1'b1, "R2 lock after aligned words", locked, 1);
    compareAll();
    modeDrv = 2'd3;
    repeat (4) sendWord(1);
    modeDrv = 2'd1;
    repeat (10) sendWord(1);
    modeDrv = 2'd2;
    repeat (10) sendWord(1);
    sendWord(0);
    repeat (3) sendWord(1);
    sendWord(0);
    sendWord(0);
    repeat (7) sendWord(1);
    tick(0, 4'h0); tick(1, 4'hf);
    modeDrv = 2'd1;
    repeat (12) sendWord(1);
    modeDrv = 2'd0;
    repeat (6) sendWord(1);
    repeat (3) tick(0, 4'h0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule